// File: doc/BRIEF.md
# Sync Pulse Qualifier for Vertical Mode Recognition

This block sits beside a vertical countdown counter in a video timing path. Two sync inputs arrive already synchronised to the 32×line-rate clock: the composite sync and the integrated vertical sync. From these it derives two per-field indications for a downstream mode controller. The first shows that the vertical interval carried a full set of equalizing and serration pulses. The second shows that the active picture was disturbed by spurious vertical-sync pulses, which signals noise or a channel change.

The countdown counter supplies three plain control inputs. A one-cycle field strobe starts each field. A vertical-window gate is nominally six lines, or 192 clocks. An active-scan gate is nominally 384 lines. Each pulse counts once, on its rising edge, and only while its own gate is high. The two counters saturate at their thresholds and return to zero at the field strobe. Each flag is captured when its gate closes, and it then holds until that gate closes again, so it stays steady across the field strobe.

All pins are plain control and status levels. No data stream crosses this boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `sync_pulse_qualifier`

## Requirements
- R1: While rst_n is low, both flags and both internal counts are 0, and they remain 0 until a gate closes after reset.
- R2: Each rising edge of csync_i in a cycle where vwin_i is high and field_strobe_i is low adds exactly one to the equalizing count. A high level that lasts many cycles adds one only.
- R3: In the cycle after vwin_i falls (high in one cycle, low in the next), eq_ok_o takes 1 if the equalizing count has reached EQ_MIN (default 9), and 0 otherwise. A count of 8 gives 0.
- R4: Rising edges of csync_i while vwin_i is low do not change the equalizing count. The bench shows this with stray pulses placed ahead of the window.
- R5: Each rising edge of vsync_i while scan_win_i is high and field_strobe_i is low adds one to the noise count. Edges outside that gate are ignored. In the cycle after scan_win_i falls, noise_o takes 1 if the count has reached NOISE_MIN (default 2), and 0 otherwise.
- R6: Each count saturates at its threshold and never wraps. With the 4-bit equalizing counter, 17 pulses still give eq_ok_o = 1. With the 2-bit noise counter, 4 pulses still give noise_o = 1.
- R7: A field strobe clears both counts to 0 in the next cycle. A rising edge that arrives in the strobe cycle is not counted.
- R8: eq_ok_o and noise_o change only in the cycle after their own gate falls. At all other times they hold, and this includes across the field strobe.
- R9: Noise pulses from 5 to 50 clocks wide are each counted once, including pulses placed 4000 to 6000 clocks into the active-scan gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32×line-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_strobe_i | input | 1 | One-cycle start-of-field pulse; clears both counts |
| vwin_i | input | 1 | Vertical-window gate for equalizing pulses |
| scan_win_i | input | 1 | Active-scan gate for noise pulses |
| csync_i | input | 1 | Synchronised composite sync |
| vsync_i | input | 1 | Synchronised integrated vertical sync |
| eq_ok_o | output | 1 | Equalizing pulse count reached EQ_MIN in the last window |
| noise_o | output | 1 | Noise count reached NOISE_MIN in the last scan window |

## Verification
The assertions rely on two input conditions. The gates and the strobe must be clean single-clock-domain levels. The field strobe must never be held for more than one cycle in a way that hides a window close. From these, the assertions require that counts move by at most one per cycle, stay frozen while their gate is low, and never pass their threshold. The bench drives every input on the falling clock edge. It opens each window for a fixed length, 192 clocks for the vertical window and 7000 for the scan window. It places pulses inside or just outside the windows by plain cycle counting, and it lowers each gate only after its last pulse has finished. The case where a pulse coincides with the strobe is also driven.

// File: rtl/sync_qual_pkg.sv
package sync_qual_pkg;

  // Default qualification thresholds.
  parameter int EQ_MIN_DEF    = 9;
  parameter int NOISE_MIN_DEF = 2;

  // Per-cycle events derived from one input/gate pair.
  typedef struct packed {
    logic rise;   // rising edge of the sync input this cycle
    logic close;  // gate was high last cycle and is low now
  } qual_evt_t;

endpackage

// File: rtl/sync_qual_edge.sv
module sync_qual_edge
  import sync_qual_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sig_i,
  input  logic      gate_i,
  output qual_evt_t evt_o
);

  logic sig_q;
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      sig_q  <= sig_i;
      gate_q <= gate_i;
    end
  end

  always_comb begin
    evt_o.rise  = sig_i & ~sig_q;
    evt_o.close = gate_q & ~gate_i;
  end

endmodule

// File: rtl/sync_qual_count.sv
module sync_qual_count #(
  parameter int THRESH = 9,
  parameter int W      = $clog2(THRESH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         full_o
);

  localparam logic [W-1:0] LIMIT = W'(THRESH);
  localparam logic [W-1:0] ONE   = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q < LIMIT)) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q >= LIMIT);

endmodule

// File: rtl/sync_qual_latch.sv
module sync_qual_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic close_i,
  input  logic full_i,
  output logic flag_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
    end else if (close_i) begin
      flag_o <= full_i;
    end
  end

endmodule

// File: rtl/sync_qual_channel.sv
module sync_qual_channel
  import sync_qual_pkg::*;
#(
  parameter int THRESH = 9,
  parameter int W      = $clog2(THRESH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         sig_i,
  input  logic         gate_i,
  output logic [W-1:0] cnt_o,
  output logic         flag_o
);

  qual_evt_t evt;
  logic      full;
  logic      inc;

  sync_qual_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_i (sig_i),
    .gate_i(gate_i),
    .evt_o (evt)
  );

  // Only edges inside the gate count; the strobe wins over an edge.
  assign inc = evt.rise & gate_i & ~clr_i;

  sync_qual_count #(.THRESH(THRESH), .W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr_i),
    .inc_i (inc),
    .cnt_o (cnt_o),
    .full_o(full)
  );

  sync_qual_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .close_i(evt.close),
    .full_i (full),
    .flag_o (flag_o)
  );

endmodule

// File: rtl/sync_pulse_qualifier.sv
module sync_pulse_qualifier
  import sync_qual_pkg::*;
#(
  parameter int EQ_MIN    = EQ_MIN_DEF,
  parameter int NOISE_MIN = NOISE_MIN_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic field_strobe_i,
  input  logic vwin_i,
  input  logic scan_win_i,
  input  logic csync_i,
  input  logic vsync_i,
  output logic eq_ok_o,
  output logic noise_o
);

  localparam int EQ_W = $clog2(EQ_MIN + 1);
  localparam int NZ_W = $clog2(NOISE_MIN + 1);

  logic [EQ_W-1:0] eq_cnt;
  logic [NZ_W-1:0] nz_cnt;

  // Equalizing/serration pulses inside the vertical window.
  sync_qual_channel #(.THRESH(EQ_MIN), .W(EQ_W)) u_eq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (field_strobe_i),
    .sig_i (csync_i),
    .gate_i(vwin_i),
    .cnt_o (eq_cnt),
    .flag_o(eq_ok_o)
  );

  // Spurious vertical-sync pulses inside the active-scan window.
  sync_qual_channel #(.THRESH(NOISE_MIN), .W(NZ_W)) u_nz (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (field_strobe_i),
    .sig_i (vsync_i),
    .gate_i(scan_win_i),
    .cnt_o (nz_cnt),
    .flag_o(noise_o)
  );

endmodule

// File: rtl/sync_pulse_qualifier_chk.sv
module sync_pulse_qualifier_chk #(
  parameter int EQ_MIN    = 9,
  parameter int NOISE_MIN = 2,
  parameter int EQ_W      = $clog2(EQ_MIN + 1),
  parameter int NZ_W      = $clog2(NOISE_MIN + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            field_strobe_i,
  input logic            vwin_i,
  input logic            scan_win_i,
  input logic            eq_ok_o,
  input logic            noise_o,
  input logic [EQ_W-1:0] eq_cnt,
  input logic [NZ_W-1:0] nz_cnt
);

  localparam logic [EQ_W-1:0] EQ_THR  = EQ_W'(EQ_MIN);
  localparam logic [NZ_W-1:0] NZ_THR  = NZ_W'(NOISE_MIN);
  localparam logic [EQ_W-1:0] EQ_ONE  = EQ_W'(1);
  localparam logic [NZ_W-1:0] NZ_ONE  = NZ_W'(1);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!eq_ok_o && !noise_o && eq_cnt == '0 && nz_cnt == '0));

  a_r2_eq_step: assert property (@(posedge clk) disable iff (!rst_n)
    !field_strobe_i |=> (eq_cnt == $past(eq_cnt) || eq_cnt == $past(eq_cnt) + EQ_ONE));

  a_r5_nz_step: assert property (@(posedge clk) disable iff (!rst_n)
    !field_strobe_i |=> (nz_cnt == $past(nz_cnt) || nz_cnt == $past(nz_cnt) + NZ_ONE));

  a_r3_eq_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vwin_i) && !vwin_i) |=> (eq_ok_o == ($past(eq_cnt) >= EQ_THR)));

  a_r4_eq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!vwin_i && !field_strobe_i) |=> $stable(eq_cnt));

  a_r5_nz_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_win_i && !field_strobe_i) |=> $stable(nz_cnt));

  a_r6_eq_sat: assert property (@(posedge clk) disable iff (!rst_n)
    eq_cnt <= EQ_THR);

  a_r6_nz_sat: assert property (@(posedge clk) disable iff (!rst_n)
    nz_cnt <= NZ_THR);

  a_r7_strobe_clear: assert property (@(posedge clk) disable iff (!rst_n)
    field_strobe_i |=> (eq_cnt == '0 && nz_cnt == '0));

  a_r8_eq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(vwin_i) && !vwin_i) |=> $stable(eq_ok_o));

  a_r8_nz_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(scan_win_i) && !scan_win_i) |=> $stable(noise_o));

endmodule

bind sync_pulse_qualifier sync_pulse_qualifier_chk #(
  .EQ_MIN   (EQ_MIN),
  .NOISE_MIN(NOISE_MIN)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .field_strobe_i(field_strobe_i),
  .vwin_i        (vwin_i),
  .scan_win_i    (scan_win_i),
  .eq_ok_o       (eq_ok_o),
  .noise_o       (noise_o),
  .eq_cnt        (eq_cnt),
  .nz_cnt        (nz_cnt)
);

// File: tb/sync_pulse_qualifier_tb_top.sv
`timescale 1ns/1ps
module sync_pulse_qualifier_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic field_strobe_i = 1'b0;
  logic vwin_i = 1'b0;
  logic scan_win_i = 1'b0;
  logic csync_i = 1'b0;
  logic vsync_i = 1'b0;
  logic eq_ok_o;
  logic noise_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  sync_pulse_qualifier dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .field_strobe_i(field_strobe_i),
    .vwin_i        (vwin_i),
    .scan_win_i    (scan_win_i),
    .csync_i       (csync_i),
    .vsync_i       (vsync_i),
    .eq_ok_o       (eq_ok_o),
    .noise_o       (noise_o)
  );

  // Behavioural reference model built from the requirements.
  int m_eq_cnt, m_nz_cnt;
  bit m_eq, m_nz, m_cs_q, m_vs_q, m_vw_q, m_sw_q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_eq_cnt = 0; m_nz_cnt = 0; m_eq = 0; m_nz = 0;
      m_cs_q = 0; m_vs_q = 0; m_vw_q = 0; m_sw_q = 0;
    end else begin
      if (m_vw_q && !vwin_i) m_eq = (m_eq_cnt >= 9);
      if (m_sw_q && !scan_win_i) m_nz = (m_nz_cnt >= 2);
      if (field_strobe_i) begin
        m_eq_cnt = 0;
        m_nz_cnt = 0;
      end else begin
        if (csync_i && !m_cs_q && vwin_i && m_eq_cnt < 9) m_eq_cnt++;
        if (vsync_i && !m_vs_q && scan_win_i && m_nz_cnt < 2) m_nz_cnt++;
      end
      m_cs_q = csync_i; m_vs_q = vsync_i;
      m_vw_q = vwin_i;  m_sw_q = scan_win_i;
    end
  end

  // Every-clock comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp += 2;
      if (eq_ok_o !== m_eq) begin
        n_bad++;
        $display("FAIL R3 model eq_ok_o actual=%b expected=%b t=%0t", eq_ok_o, m_eq, $time);
      end
      if (noise_o !== m_nz) begin
        n_bad++;
        $display("FAIL R5 model noise_o actual=%b expected=%b t=%0t", noise_o, m_nz, $time);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  bit prev_eq = 0, prev_nz = 0;

  // One field: strobe, optional stray csync, vertical window, scan window.
  task automatic run_field(input int n_eq, input int w_eq, input int n_nz,
                           input int w_nz, input bit ovl, input bit stray,
                           input bit exp_eq, input bit exp_nz, input string tag);
    int t;
    @(negedge clk);
    field_strobe_i = 1'b1;
    if (ovl) begin vwin_i = 1'b1; vsync_i = 1'b1; csync_i = 1'b1; end
    @(negedge clk);
    field_strobe_i = 1'b0;
    chk({"R8 hold eq across strobe ", tag}, eq_ok_o, prev_eq);
    chk({"R8 hold noise across strobe ", tag}, noise_o, prev_nz);
    t = 1;
    if (ovl) begin
      repeat (w_eq - 1) @(negedge clk);
      csync_i = 1'b0;
      repeat (w_eq) @(negedge clk);
      t = 2 * w_eq;
      n_eq = n_eq - 1;
    end else begin
      if (stray) begin
        for (int i = 0; i < 3; i++) begin
          csync_i = 1'b1; repeat (4) @(negedge clk);
          csync_i = 1'b0; repeat (4) @(negedge clk);
        end
      end
      repeat (3) @(negedge clk);
      vwin_i = 1'b1; vsync_i = 1'b1;
      t = 0;
    end
    for (int i = 0; i < n_eq; i++) begin
      csync_i = 1'b1; repeat (w_eq) @(negedge clk);
      csync_i = 1'b0; repeat (w_eq) @(negedge clk);
      t += 2 * w_eq;
    end
    while (t < 192) begin @(negedge clk); t++; end
    vwin_i = 1'b0; vsync_i = 1'b0;
    chk({"R8 eq unchanged before close cycle ", tag}, eq_ok_o, prev_eq);
    repeat (2) @(negedge clk);
    chk({"R3 eq_ok_o at window close ", tag}, eq_ok_o, exp_eq);
    scan_win_i = 1'b1;
    t = 0;
    while (t < 4000) begin @(negedge clk); t++; end
    for (int i = 0; i < n_nz; i++) begin
      vsync_i = 1'b1; repeat (w_nz) @(negedge clk);
      vsync_i = 1'b0; repeat (200) @(negedge clk);
      t += w_nz + 200;
    end
    while (t < 7000) begin @(negedge clk); t++; end
    chk({"R8 noise unchanged inside scan ", tag}, noise_o, prev_nz);
    scan_win_i = 1'b0;
    repeat (2) @(negedge clk);
    chk({"R5 noise_o at scan close ", tag}, noise_o, exp_nz);
    repeat (20) @(negedge clk);
    chk({"R8 eq held late ", tag}, eq_ok_o, exp_eq);
    prev_eq = exp_eq;
    prev_nz = exp_nz;
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 eq_ok_o in reset", eq_ok_o, 1'b0);
    chk("R1 noise_o in reset", noise_o, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 eq_ok_o after reset", eq_ok_o, 1'b0);
    // R2/R3/R5/R9: nine pulses, two 5-clock noise pulses at 4000+
    run_field(9, 8, 2, 5, 0, 0, 1'b1, 1'b1, "r2_r9_nine");
    // R3 boundary: eight pulses; R5 single 50-clock pulse
    run_field(8, 8, 1, 50, 0, 0, 1'b0, 1'b0, "r3_eight");
    // R4: eight in window plus three stray before it
    run_field(8, 8, 2, 50, 0, 1, 1'b0, 1'b1, "r4_stray");
    // R6: seventeen pulses and four noise pulses saturate
    run_field(17, 5, 4, 20, 0, 0, 1'b1, 1'b1, "r6_sat");
    // R7: nine rises but first lands in the strobe cycle
    run_field(9, 8, 0, 5, 1, 0, 1'b0, 1'b0, "r7_strobe_edge");
    // R2: long 10-clock pulses, twelve-pulse window full of 8-clock pulses
    run_field(9, 10, 3, 30, 0, 0, 1'b1, 1'b1, "r2_wide");
    run_field(12, 8, 1, 5, 0, 0, 1'b1, 1'b0, "r2_full_window");
    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      report();
      $finish;
    end
  end

endmodule